// File: doc/BRIEF.md
# Sprite-Memory Page Copy Engine

This block moves a full 256-byte page of CPU address space into sprite memory. The CPU starts it by writing a page number to a trigger register, which reaches the block as a one-cycle strobe with the page value. The block then stalls the CPU and waits one or two idle cycles to line up with the bus. After that it takes two cycles per byte: in the first it reads a source byte over the CPU bus, and in the second it writes that byte to the sprite-memory data port. The data port advances the sprite-memory address after each write.

The number of idle cycles depends on whether the CPU cycle count was odd or even when the trigger arrived. This parity comes in on its own input, sampled together with the strobe. The stall output stays high for the whole operation, which lasts 513 or 514 cycles. A one-cycle completion pulse follows the last write. A strobe that arrives while a copy is running is dropped.

Top module: `spr_dma`

## Requirements
- R1: An accepted trigger captures the 8-bit page value. Every source read address is the page value in bits 15:8 and the byte index in bits 7:0.
- R2: After an accepted trigger, the stall output is high for exactly 1 cycle with no read or write when the parity input was 1 (odd). It is high for exactly 2 such cycles when the parity input was 0 (even). The first read comes after these cycles.
- R3: One copy performs exactly 256 reads, with byte indices 0 through 255 in ascending order.
- R4: Each read cycle is followed in the next cycle by a write cycle. That write drives the byte returned on the read-data input during the read cycle.
- R5: The stall output rises in the cycle after the accepting clock edge and stays high until the last write cycle ends. That is 513 cycles for odd parity and 514 for even.
- R6: A trigger that arrives while the stall output is high has no effect on the page, the byte count or the timing of the running copy.
- R7: The done output is high for exactly one cycle, directly after the final write cycle, and the stall output is low in that cycle.
- R8: During and right after reset, the stall, read-enable, write-enable and done outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | One-cycle strobe: page number written |
| trig_page_i | input | 8 | Source page number |
| cyc_odd_i | input | 1 | 1 when the current CPU cycle count is odd |
| rd_en_o | output | 1 | Source read cycle on the CPU bus |
| rd_addr_o | output | 16 | Source byte address |
| rd_data_i | input | 8 | Byte returned by the CPU bus in the read cycle |
| spr_wr_o | output | 1 | Write strobe to the sprite-memory data port |
| spr_wdata_o | output | 8 | Byte written to sprite memory |
| halt_o | output | 1 | Stalls the CPU while the copy runs |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The copy is run with odd and even parity and with pages 0x00, 0x02 and 0xFF. Comparing the two parities shows whether the idle-cycle count and the total stall length follow the parity input. Using different pages shows whether the page lands in the upper address byte, and page 0xFF also covers the top of the address space. The bus model returns a byte computed from each address, so a skipped, repeated or reordered read, or a stale latched byte, shows up as a mismatch. A second trigger with a different page and parity is fired in the middle of a copy, to confirm it changes neither the addresses nor the timing.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;
  typedef enum logic [1:0] {
    DMA_IDLE  = 2'd0,
    DMA_ALIGN = 2'd1,
    DMA_READ  = 2'd2,
    DMA_WRITE = 2'd3
  } dma_state_e;
endpackage

// File: rtl/spr_dma_ctrl.sv
module spr_dma_ctrl
  import spr_dma_pkg::*;
#(
  parameter int XFER_LEN = 256,
  localparam int CNT_W = $clog2(XFER_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             odd_i,
  output logic             accept_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             rd_en_o,
  output logic             wr_en_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(XFER_LEN - 1);

  dma_state_e       state_q, state_d;
  logic             extra_q, extra_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             done_q, done_d;

  always_comb begin
    state_d  = state_q;
    extra_d  = extra_q;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    done_d   = 1'b0;
    accept_o = 1'b0;
    case (state_q)
      DMA_IDLE: begin
        if (trig_i) begin
          accept_o = 1'b1;
          state_d  = DMA_ALIGN;
          extra_d  = ~odd_i;
          idx_d    = '0;
          idx_en   = 1'b1;
        end
      end
      DMA_ALIGN: begin
        if (extra_q) extra_d = 1'b0;
        else         state_d = DMA_READ;
      end
      DMA_READ: state_d = DMA_WRITE;
      DMA_WRITE: begin
        if (idx_q == LAST_IDX) begin
          state_d = DMA_IDLE;
          done_d  = 1'b1;
        end else begin
          idx_d   = idx_q + 1'b1;
          idx_en  = 1'b1;
          state_d = DMA_READ;
        end
      end
      default: state_d = DMA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DMA_IDLE;
      extra_q <= 1'b0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      extra_q <= extra_d;
      done_q  <= done_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign idx_o   = idx_q;
  assign rd_en_o = (state_q == DMA_READ);
  assign wr_en_o = (state_q == DMA_WRITE);
  assign busy_o  = (state_q != DMA_IDLE);
  assign done_o  = done_q;

  // R4
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> wr_en_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(wr_en_o)));
  // R2
  align_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (!rd_en_o && !wr_en_o));
  // R5
  halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
endmodule

// File: rtl/spr_dma_datapath.sv
module spr_dma_datapath #(
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = PAGE_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [PAGE_W-1:0] base_q, base_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              base_en, byte_en;

  always_comb begin
    base_en = accept_i;
    base_d  = page_i;
    byte_en = rd_en_i;
    byte_d  = rd_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      byte_q <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      if (byte_en) byte_q <= byte_d;
    end
  end

  assign rd_addr_o = {base_q, idx_i};
  assign wdata_o   = byte_q;

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> $stable(base_q));
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && $past(wr_en_i)) |-> (rd_addr_o == $past(rd_addr_o, 2) + 1'b1));
  // R4
  write_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> (wdata_o == $past(rd_data_i)));
endmodule

// File: rtl/spr_dma.sv
module spr_dma #(
  parameter int PAGE_W   = 8,
  parameter int XFER_LEN = 256,
  parameter int DATA_W   = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                trig_i,
  input  logic [PAGE_W-1:0]                   trig_page_i,
  input  logic                                cyc_odd_i,
  output logic                                rd_en_o,
  output logic [PAGE_W+$clog2(XFER_LEN)-1:0]  rd_addr_o,
  input  logic [DATA_W-1:0]                   rd_data_i,
  output logic                                spr_wr_o,
  output logic [DATA_W-1:0]                   spr_wdata_o,
  output logic                                halt_o,
  output logic                                done_o
);
  localparam int CNT_W = $clog2(XFER_LEN);

  logic             accept;
  logic [CNT_W-1:0] idx;
  logic             rd_en, wr_en, busy;

  spr_dma_ctrl #(.XFER_LEN(XFER_LEN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_i   (trig_i),
    .odd_i    (cyc_odd_i),
    .accept_o (accept),
    .idx_o    (idx),
    .rd_en_o  (rd_en),
    .wr_en_o  (wr_en),
    .busy_o   (busy),
    .done_o   (done_o)
  );

  spr_dma_datapath #(.PAGE_W(PAGE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .page_i    (trig_page_i),
    .idx_i     (idx),
    .rd_en_i   (rd_en),
    .wr_en_i   (wr_en),
    .busy_i    (busy),
    .rd_data_i (rd_data_i),
    .rd_addr_o (rd_addr_o),
    .wdata_o   (spr_wdata_o)
  );

  assign rd_en_o  = rd_en;
  assign spr_wr_o = wr_en;
  assign halt_o   = busy;
endmodule

// File: tb/spr_dma_tb.sv
module spr_dma_tb;
  logic        clk, rst_n;
  logic        trig, odd;
  logic [7:0]  page;
  logic        rd_en, spr_wr, halt, done;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data, wdata;

  int checks = 0, fails = 0;

  spr_dma u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .trig_page_i(page),
    .cyc_odd_i(odd), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .spr_wr_o(spr_wr), .spr_wdata_o(wdata),
    .halt_o(halt), .done_o(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
  endfunction
  assign rd_data = mem_f(rd_addr);

  // monitor, sampled on falling edges
  logic [15:0] rd_log [0:255];
  logic [7:0]  wr_log [0:255];
  logic [7:0]  exp_wr [0:255];
  int rd_n, wr_n, halt_n, idle_n, done_n, pair_err;
  logic seen_rd, prev_rd, done_halt;

  task automatic clear_mon();
    rd_n = 0; wr_n = 0; halt_n = 0; idle_n = 0; done_n = 0; pair_err = 0;
    seen_rd = 1'b0; prev_rd = 1'b0; done_halt = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (halt) halt_n++;
      if (halt && !seen_rd && !rd_en && !spr_wr) idle_n++;
      if (rd_en) begin
        if (rd_n < 256) begin
          rd_log[rd_n] = rd_addr;
          exp_wr[rd_n] = rd_data;
        end
        rd_n++;
        seen_rd = 1'b1;
      end
      if (spr_wr) begin
        if (wr_n < 256) wr_log[wr_n] = wdata;
        wr_n++;
        if (!prev_rd) pair_err++;
      end
      if (done) begin
        done_n++;
        if (halt) done_halt = 1'b1;
      end
      prev_rd = rd_en;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic pulse(input logic [7:0] p, input logic o);
    @(negedge clk);
    trig = 1'b1; page = p; odd = o;
    @(negedge clk);
    trig = 1'b0; page = 8'hEE; odd = ~o;
  endtask

  task automatic wait_done();
    while (done_n == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input logic [7:0] p, input logic o);
    int bad_addr = 0, bad_data = 0;
    check("R2 idle cycles", idle_n, o ? 1 : 2);
    check("R5 halt length", halt_n, o ? 513 : 514);
    check("R3 read count", rd_n, 256);
    check("R4 write count", wr_n, 256);
    check("R4 read-write pairing", pair_err, 0);
    for (int i = 0; i < 256; i++) begin
      if (rd_log[i] != {p, 8'(i)}) bad_addr++;
      if (wr_log[i] != mem_f({p, 8'(i)})) bad_data++;
      if (wr_log[i] != exp_wr[i]) bad_data++;
    end
    check("R1 R3 read addresses", bad_addr, 0);
    check("R4 write data", bad_data, 0);
    check("R7 done pulses", done_n, 1);
    check("R7 halt low at done", int'(done_halt), 0);
    check("R5 halt released", int'(halt), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; trig = 1'b0; page = 8'h00; odd = 1'b0;
    clear_mon();
    repeat (3) @(negedge clk);
    check("R8 halt in reset", int'(halt), 0);
    check("R8 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 rd_en after reset", int'(rd_en), 0);
    check("R8 spr_wr after reset", int'(spr_wr), 0);
  endtask

  task automatic t_copy(input logic [7:0] p, input logic o);
    clear_mon();
    pulse(p, o);
    check("R5 halt after trigger", int'(halt), 1);
    wait_done();
    verify(p, o);
  endtask

  task automatic t_busy_trigger();
    clear_mon();
    pulse(8'h02, 1'b0);
    repeat (20) @(negedge clk);
    pulse(8'h7C, 1'b1);
    repeat (100) @(negedge clk);
    pulse(8'h11, 1'b1);
    wait_done();
    // R6: second and third strobes must not alter page or timing
    verify(8'h02, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    t_reset();
    t_copy(8'h02, 1'b1);
    t_copy(8'h02, 1'b0);
    t_copy(8'hFF, 1'b0);
    t_copy(8'h00, 1'b1);
    t_busy_trigger();
    report();
  end
endmodule